// File: doc/BRIEF.md
# Two-Stage Transmit Audio Buffer

This block sits between a processor-side sample write port and a serial audio transmitter that takes one sample per frame slot. It holds at most two samples, in an output-side stage and an input-side stage. Samples leave in the order they were written. Each frame slot, the transmitter raises a request, and the oldest held sample is handed over on a registered output.

When a request arrives and neither stage holds data, the buffer does not stall and does not send silence. It presents the last sample it sent once more and raises a one-cycle underrun event. Status logic elsewhere can turn that event into a sticky flag that software clears. A space indication tells the writer whether its next write will be taken.

Top module: `aud_tx_buf2`

## Requirements
- R1: After reset, `sample_o` is zero, `underrun_o` is low and `space_o` is high.
- R2: Samples reach `sample_o` in the order they were written.
- R3: A request while at least one sample is held makes `sample_o` show the oldest held sample in the cycle after the request, with `underrun_o` low in that cycle.
- R4: A request while no sample is held leaves `sample_o` unchanged and makes `underrun_o` high in the cycle after the request.
- R5: A request that finds the buffer empty before any sample has been written gives zero on `sample_o`.
- R6: `underrun_o` is high for exactly one cycle for every request that finds the buffer empty, so back-to-back empty requests give one pulse each. It is low in every cycle that follows a cycle without a request.
- R7: `space_o` is low exactly when two samples are held. A write in a cycle where `space_o` is low is dropped, even if a request comes in the same cycle, and the held samples stay as they were.
- R8: When a write and a request arrive in the same cycle, the request is served from the samples held before the write. If the buffer was empty, this gives an underrun. The written sample is stored in either case.
- R9: The buffer holds exactly two samples. After two writes and two requests, a third request is an underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Sample write strobe |
| wr_data_i | input | DW | Sample to write |
| req_i | input | 1 | Per-frame sample request from the encoder |
| sample_o | output | DW | Sample presented to the encoder (last sent) |
| space_o | output | 1 | High when a write would be accepted |
| underrun_o | output | 1 | One-cycle pulse per request that finds the buffer empty |

## Verification
The checker watches, on every cycle, how a request relates to the next cycle. A request on an empty buffer must give a pulse and a held sample. A request on a non-empty buffer must give the head sample with no pulse. A cycle without a request must give no pulse. A full buffer that gets no request must keep its head sample and stay full. The scenarios in the bench show what the checker cannot see: the order of samples across several writes, the zero value on a first underrun, that a write into a full buffer is really dropped, and the split of a write and a request in the same cycle, tested both with an empty buffer and with one sample held.

// File: rtl/atb_pkg.sv
package atb_pkg;
    parameter int unsigned ATB_DW = 24;

    typedef enum logic [1:0] {
        OCC_NONE = 2'd0,
        OCC_ONE  = 2'd1,
        OCC_TWO  = 2'd2
    } occ_e;
endpackage

// File: rtl/atb_stages.sv
module atb_stages #(
    parameter int unsigned DW = atb_pkg::ATB_DW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic          head_vld_o,
    output logic [DW-1:0] head_data_o,
    output logic          full_o
);
    typedef struct packed {
        atb_pkg::occ_e occ;
        logic [DW-1:0] outs;   // output-side stage, oldest sample
        logic [DW-1:0] ins;    // input-side stage, newer sample
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.occ)
            atb_pkg::OCC_NONE: begin
                if (push_i) begin
                    st_d.outs = push_data_i;
                    st_d.occ  = atb_pkg::OCC_ONE;
                end
            end
            atb_pkg::OCC_ONE: begin
                if (pop_i && push_i) begin
                    st_d.outs = push_data_i;
                end else if (pop_i) begin
                    st_d.occ = atb_pkg::OCC_NONE;
                end else if (push_i) begin
                    st_d.ins = push_data_i;
                    st_d.occ = atb_pkg::OCC_TWO;
                end
            end
            atb_pkg::OCC_TWO: begin
                // a write while full is dropped, even alongside a pop
                if (pop_i) begin
                    st_d.outs = st_q.ins;
                    st_d.occ  = atb_pkg::OCC_ONE;
                end
            end
            default: st_d.occ = atb_pkg::OCC_NONE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{occ: atb_pkg::OCC_NONE, outs: '0, ins: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign head_vld_o  = (st_q.occ != atb_pkg::OCC_NONE);
    assign head_data_o = st_q.outs;
    assign full_o      = (st_q.occ == atb_pkg::OCC_TWO);
endmodule

// File: rtl/atb_emit.sv
module atb_emit #(
    parameter int unsigned DW = atb_pkg::ATB_DW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_i,
    input  logic          head_vld_i,
    input  logic [DW-1:0] head_data_i,
    output logic [DW-1:0] sample_o,
    output logic          underrun_o
);
    typedef struct packed {
        logic [DW-1:0] last;
        logic          urun;
    } em_t;

    em_t em_d, em_q;

    always_comb begin
        em_d      = em_q;
        em_d.urun = 1'b0;
        if (req_i) begin
            if (head_vld_i) begin
                em_d.last = head_data_i;
            end else begin
                em_d.urun = 1'b1;   // repeat last sample
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            em_q <= '{last: '0, urun: 1'b0};
        end else begin
            em_q <= em_d;
        end
    end

    assign sample_o   = em_q.last;
    assign underrun_o = em_q.urun;
endmodule

// File: rtl/aud_tx_buf2.sv
module aud_tx_buf2 #(
    parameter int unsigned DW = atb_pkg::ATB_DW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          req_i,
    output logic [DW-1:0] sample_o,
    output logic          space_o,
    output logic          underrun_o
);
    logic          head_vld;
    logic [DW-1:0] head_dat;
    logic          full;
    logic          pop;

    assign pop     = req_i & head_vld;
    assign space_o = ~full;

    atb_stages #(.DW(DW)) i_stages (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (wr_en_i),
        .push_data_i (wr_data_i),
        .pop_i       (pop),
        .head_vld_o  (head_vld),
        .head_data_o (head_dat),
        .full_o      (full)
    );

    atb_emit #(.DW(DW)) i_emit (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_i       (req_i),
        .head_vld_i  (head_vld),
        .head_data_i (head_dat),
        .sample_o    (sample_o),
        .underrun_o  (underrun_o)
    );
endmodule

// File: rtl/atb_chk.sv
module atb_chk #(
    parameter int unsigned DW = atb_pkg::ATB_DW
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          req_i,
    input logic [DW-1:0] sample_o,
    input logic          space_o,
    input logic          underrun_o,
    input logic          head_vld,
    input logic [DW-1:0] head_dat
);
    // R4
    underrun_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i && !head_vld |=> underrun_o && $stable(sample_o));

    // R6
    quiet_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !underrun_o);

    // R3
    serve_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i && head_vld |=> !underrun_o && (sample_o == $past(head_dat)));

    // R7
    full_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !space_o && !req_i |=> !space_o && $stable(head_dat));

    // R7
    full_has_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !space_o |-> head_vld);
endmodule

bind aud_tx_buf2 atb_chk #(.DW(DW)) i_atb_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .sample_o   (sample_o),
    .space_o    (space_o),
    .underrun_o (underrun_o),
    .head_vld   (head_vld),
    .head_dat   (head_dat)
);

// File: tb/test_aud_tx_buf2.sv
module test_aud_tx_buf2;
    localparam int unsigned DW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          req = 1'b0;
    logic [DW-1:0] sample;
    logic          space;
    logic          urun;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    aud_tx_buf2 #(.DW(DW)) i_aud_tx_buf2 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .req_i      (req),
        .sample_o   (sample),
        .space_o    (space),
        .underrun_o (urun)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // apply inputs for one cycle, then sample just after the edge
    task automatic step(input logic w, input logic [DW-1:0] d, input logic r);
        wr_en = w; wr_data = d; req = r;
        @(posedge clk); #1;
        wr_en = 1'b0; req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 sample", sample, '0);
        chk("R1 underrun", DW'(urun), '0);
        chk("R1 space", DW'(space), DW'(1));
    endtask

    task automatic t_first_underrun;
        step(0, '0, 1);
        chk("R5 zero sample", sample, '0);
        chk("R4 underrun pulse", DW'(urun), DW'(1));
        step(0, '0, 0);
        chk("R6 pulse ends", DW'(urun), '0);
    endtask

    task automatic t_order;
        step(1, 24'hA1A1A1, 0);
        chk("R7 space one held", DW'(space), DW'(1));
        step(1, 24'hB2B2B2, 0);
        chk("R7 space full", DW'(space), '0);
        step(0, '0, 1);
        chk("R3 first out", sample, 24'hA1A1A1);
        chk("R3 no underrun", DW'(urun), '0);
        step(0, '0, 1);
        chk("R2 second out", sample, 24'hB2B2B2);
        step(0, '0, 1);
        chk("R4 repeat last", sample, 24'hB2B2B2);
        chk("R4 underrun", DW'(urun), DW'(1));
        step(0, '0, 1);
        chk("R6 second pulse", DW'(urun), DW'(1));
        step(0, '0, 0);
        chk("R6 quiet", DW'(urun), '0);
    endtask

    task automatic t_full_ignore;
        step(1, 24'hC3C3C3, 0);
        step(1, 24'hD4D4D4, 0);
        step(1, 24'hEEEEEE, 0);
        chk("R7 full write dropped space", DW'(space), '0);
        step(1, 24'hFFFFFF, 1);
        chk("R7 oldest intact", sample, 24'hC3C3C3);
        chk("R7 space after pop", DW'(space), DW'(1));
        step(0, '0, 1);
        chk("R7 second intact", sample, 24'hD4D4D4);
        step(0, '0, 1);
        chk("R9 third request underruns", DW'(urun), DW'(1));
        chk("R9 repeat", sample, 24'hD4D4D4);
    endtask

    task automatic t_same_cycle;
        step(1, 24'h515151, 1);
        chk("R8 empty underrun", DW'(urun), DW'(1));
        chk("R8 sample held", sample, 24'hD4D4D4);
        step(0, '0, 1);
        chk("R8 write stored", sample, 24'h515151);
        chk("R8 no underrun", DW'(urun), '0);
        step(1, 24'h626262, 0);
        step(1, 24'h737373, 1);
        chk("R8 served old", sample, 24'h626262);
        chk("R8 one held", DW'(space), DW'(1));
        step(0, '0, 1);
        chk("R8 new follows", sample, 24'h737373);
        step(0, '0, 1);
        chk("R8 drained", DW'(urun), DW'(1));
    endtask

    initial begin
        #1000000;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #12 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_first_underrun();
        t_order();
        t_full_ignore();
        t_same_cycle();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule